// File: doc/BRIEF.md
# Fixed-Priority Nesting Interrupt Controller

This block sits next to a small 8-bit core and decides which interrupt the core should service next. It gathers one non-maskable request pin (active-low, asynchronous), two external request lines, and a parameterized set of peripheral flag/enable pairs. Maskable sources pass through a global enable and their own enables. It presents a single request with a 3-bit vector number to the core. The core answers with an acknowledge pulse when it enters the presented handler and with a return pulse when a handler ends.

The controller keeps a service context: normal code, a maskable handler, or a non-maskable handler. In the last case it also remembers whether a maskable handler was preempted. Only the non-maskable source may interrupt a running handler, and never its own. Maskable handlers never nest. Peripheral flags are level signals that software clears, so a serviced but uncleared flag requests again. A wake output tells the clock controller when a pending source should end WAIT or STOP mode.

Top module: `irq_nest_ctrl`

## Requirements
- R1: A falling edge on `nmi_n` is latched as a vector-0 request whatever `glb_en` is. The request is visible on `irq_req`/`irq_vec` after the third rising clock edge that follows `nmi_n` going low. It is not visible after the second.
- R2: An acknowledge while vector 0 is presented clears the non-maskable latch. Holding `nmi_n` low afterwards raises no new request; only a fresh falling edge does.
- R3: A pending vector-0 request is granted while a maskable handler runs (`ctx` 1). It is never granted while `ctx` is 2 or 3. An edge that arrives during a non-maskable handler stays latched and is presented once `ctx` returns to 1 or 0.
- R4: While `ctx` is not 0, no vector from 1 to 4 is presented, so maskable handlers do not nest.
- R5: In `ctx` 0 the presented vector is the lowest-numbered pending one, with 0 above 1 above 2 above 3 above 4. `irq_vec` carries the vector number in binary.
- R6: Vector 1 is pending when `ext_req[0]`, `ext_en[0]` and `glb_en` are all 1. Vector 2 is pending for the same condition on bit 1.
- R7: Peripheral k is active when `per_flag[k]`, `per_en[k]` and `glb_en` are all 1. An active peripheral drives vector 4 if bit k of `PER_VEC4_MASK` is 1, and vector 3 otherwise. A flag still held after the handler returns requests again.
- R8: `wake` is 0 when `lp_mode` is 0 (run) or 3. When `lp_mode` is 1 (WAIT), `wake` is 1 whenever any of vectors 0 to 4 is pending, even one the context blocks. When `lp_mode` is 2 (STOP), `wake` is 1 only for the non-maskable latch, a pending vector 1 or 2, or an active peripheral whose bit in `PER_STOP_MASK` is 1.
- R9: Synchronous reset sets `ctx` to 0 and clears the non-maskable latch, which abandons any handler in progress.
- R10: `ctx` is encoded as 0 normal, 1 maskable, 2 non-maskable over normal, and 3 non-maskable over maskable. An acknowledge of vector 0 moves 0 to 2 or 1 to 3. An acknowledge of any other vector moves 0 to 1. A return moves 3 to 1, 2 to 0 and 1 to 0, and leaves 0 as it is. An acknowledge while `irq_req` is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_n | input | 1 | Asynchronous non-maskable request, active on falling edge |
| ext_req | input | 2 | External request lines for vectors 1 and 2 |
| ext_en | input | 2 | Per-line enables for the external requests |
| glb_en | input | 1 | Global enable for all maskable sources |
| per_flag | input | NPER | Peripheral request flags, held until software clears them |
| per_en | input | NPER | Peripheral enables |
| lp_mode | input | 2 | Low-power mode: 0 run, 1 WAIT, 2 STOP, 3 treated as run |
| ack | input | 1 | Core pulse: entering the presented handler |
| rti | input | 1 | Core pulse: handler finished |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 3 | Presented vector number |
| wake | output | 1 | Wake request for the current low-power mode |
| ctx | output | 2 | Current service context |

## Verification
The hardest situation to reach is a second non-maskable edge that lands while a non-maskable handler is already preempting a maskable one. It must stay latched but invisible, and then appear as soon as the return drops the context back to maskable service. The stimulus gets there in steps. It acknowledges an external vector first, then re-arms `nmi_n` high long enough to pass the synchronizer and drives a falling edge. After acknowledging that edge it drives another full high-low cycle, and then walks the context back down with return pulses, checking the presented vector at each step. A full sweep over the enables and flags in each low-power mode covers the priority and wake arithmetic.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int VEC_W = 3;
    localparam int NVEC  = 5;

    typedef enum logic [1:0] {
        CTX_NORM     = 2'd0,
        CTX_MASK     = 2'd1,
        CTX_NMI      = 2'd2,
        CTX_NMI_NEST = 2'd3
    } ctx_t;

    typedef enum logic [1:0] {
        LP_RUN  = 2'd0,
        LP_WAIT = 2'd1,
        LP_STOP = 2'd2,
        LP_RSVD = 2'd3
    } lp_t;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } grant_t;

    // lowest-numbered pending vector wins
    function automatic grant_t pick_vec(input logic [NVEC-1:0] pend);
        grant_t g;
        g = '0;
        for (int i = NVEC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                g.valid = 1'b1;
                g.vec   = VEC_W'(i);
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n,
    input  logic ack_nmi,
    output logic nmi_pend
);
    logic sync1, sync2, sync3;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            sync3 <= 1'b1;
        end else begin
            sync1 <= nmi_n;
            sync2 <= sync1;
            sync3 <= sync2;
        end
    end

    assign fall = sync3 & ~sync2;

    always_ff @(posedge clk) begin
        if (rst)          nmi_pend <= 1'b0;
        else if (fall)    nmi_pend <= 1'b1;
        else if (ack_nmi) nmi_pend <= 1'b0;
    end

    // R2
    nmi_ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_nmi && !fall) |=> !nmi_pend);

    // R1
    nmi_edge_set_chk: assert property (@(posedge clk) disable iff (rst)
        fall |=> nmi_pend);

endmodule

// File: rtl/irq_src_pend.sv
module irq_src_pend #(
    parameter int          NPER          = 4,
    parameter logic [NPER-1:0] PER_VEC4_MASK = '0,
    parameter logic [NPER-1:0] PER_STOP_MASK = '0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          glb_en,
    input  logic [1:0]                    ext_req,
    input  logic [1:0]                    ext_en,
    input  logic [NPER-1:0]               per_flag,
    input  logic [NPER-1:0]               per_en,
    input  logic                          nmi_pend,
    output logic [irq_nest_pkg::NVEC-1:0] pend,
    output logic                          stop_src
);
    logic [NPER-1:0] hit;
    logic [NPER-1:0] to_v3;
    logic [NPER-1:0] to_v4;
    logic [NPER-1:0] stop_hit;

    for (genvar k = 0; k < NPER; k++) begin : g_per
        assign hit[k]      = per_flag[k] & per_en[k] & glb_en;
        assign stop_hit[k] = hit[k] & PER_STOP_MASK[k];
        if (PER_VEC4_MASK[k]) begin : g_v4
            assign to_v4[k] = hit[k];
            assign to_v3[k] = 1'b0;
        end else begin : g_v3
            assign to_v3[k] = hit[k];
            assign to_v4[k] = 1'b0;
        end
    end

    assign pend[0] = nmi_pend;
    assign pend[1] = ext_req[0] & ext_en[0] & glb_en;
    assign pend[2] = ext_req[1] & ext_en[1] & glb_en;
    assign pend[3] = |to_v3;
    assign pend[4] = |to_v4;

    assign stop_src = nmi_pend | pend[1] | pend[2] | (|stop_hit);

    // R6
    glb_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !glb_en |-> (pend[4:1] == '0));

    // R7
    per_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (per_flag == '0) |-> (pend[4:3] == '0));

endmodule

// File: rtl/irq_ctx_fsm.sv
module irq_ctx_fsm
    import irq_nest_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NVEC-1:0] pend,
    input  logic            ack,
    input  logic            rti,
    output grant_t          grant,
    output logic            ack_nmi,
    output ctx_t            ctx
);
    ctx_t ctx_nx;

    always_comb begin
        grant = '0;
        unique case (ctx)
            CTX_NORM: grant = pick_vec(pend);
            CTX_MASK: begin
                grant.valid = pend[0];
                grant.vec   = '0;
            end
            default:  grant = '0;
        endcase
    end

    assign ack_nmi = ack && grant.valid && (grant.vec == '0);

    always_comb begin
        ctx_nx = ctx;
        if (ack && grant.valid) begin
            if (grant.vec == '0)
                ctx_nx = (ctx == CTX_MASK) ? CTX_NMI_NEST : CTX_NMI;
            else
                ctx_nx = CTX_MASK;
        end else if (rti) begin
            unique case (ctx)
                CTX_NMI_NEST: ctx_nx = CTX_MASK;
                CTX_NMI:      ctx_nx = CTX_NORM;
                CTX_MASK:     ctx_nx = CTX_NORM;
                default:      ctx_nx = CTX_NORM;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctx <= CTX_NORM;
        else     ctx <= ctx_nx;
    end

    // R4
    no_mask_nest_chk: assert property (@(posedge clk) disable iff (rst)
        (grant.valid && ctx != CTX_NORM) |-> (grant.vec == '0));

    // R3
    no_nmi_in_nmi_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx == CTX_NMI || ctx == CTX_NMI_NEST) |-> !grant.valid);

    // R10
    nest_return_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx == CTX_NMI_NEST && rti && !ack) |=> (ctx == CTX_MASK));

    // R10
    idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!grant.valid && !rti) |=> $stable(ctx));

    // R9
    reset_ctx_chk: assert property (@(posedge clk)
        rst |=> (ctx == CTX_NORM));

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int              NPER          = 4,
    parameter logic [NPER-1:0] PER_VEC4_MASK = 4'b1100,
    parameter logic [NPER-1:0] PER_STOP_MASK = 4'b0101
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_n,
    input  logic [1:0]       ext_req,
    input  logic [1:0]       ext_en,
    input  logic             glb_en,
    input  logic [NPER-1:0]  per_flag,
    input  logic [NPER-1:0]  per_en,
    input  logic [1:0]       lp_mode,
    input  logic             ack,
    input  logic             rti,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic             wake,
    output logic [1:0]       ctx
);
    logic            nmi_pend;
    logic            ack_nmi;
    logic [NVEC-1:0] pend;
    logic            stop_src;
    grant_t          grant;
    ctx_t            ctx_q;

    irq_nmi_edge u_nmi (
        .clk      (clk),
        .rst      (rst),
        .nmi_n    (nmi_n),
        .ack_nmi  (ack_nmi),
        .nmi_pend (nmi_pend)
    );

    irq_src_pend #(
        .NPER          (NPER),
        .PER_VEC4_MASK (PER_VEC4_MASK),
        .PER_STOP_MASK (PER_STOP_MASK)
    ) u_pend (
        .clk      (clk),
        .rst      (rst),
        .glb_en   (glb_en),
        .ext_req  (ext_req),
        .ext_en   (ext_en),
        .per_flag (per_flag),
        .per_en   (per_en),
        .nmi_pend (nmi_pend),
        .pend     (pend),
        .stop_src (stop_src)
    );

    irq_ctx_fsm u_ctx (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend),
        .ack     (ack),
        .rti     (rti),
        .grant   (grant),
        .ack_nmi (ack_nmi),
        .ctx     (ctx_q)
    );

    assign irq_req = grant.valid;
    assign irq_vec = grant.vec;
    assign ctx     = ctx_q;

    always_comb begin
        unique case (lp_t'(lp_mode))
            LP_WAIT: wake = |pend;
            LP_STOP: wake = stop_src;
            default: wake = 1'b0;
        endcase
    end

    // R8
    run_no_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (lp_mode == 2'd0 || lp_mode == 2'd3) |-> !wake);

    // R8
    stop_implies_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (lp_mode == 2'd2 && wake) |-> (pend != '0));

endmodule

// File: tb/irq_nest_ctrl_tb_top.sv
module irq_nest_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPER = 4;
    localparam logic [NPER-1:0] V4M = 4'b1100;
    localparam logic [NPER-1:0] STM = 4'b0101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nmi_n = 1'b1;
    logic [1:0] ext_req = '0, ext_en = '0, lp_mode = '0;
    logic glb_en = 1'b0;
    logic [NPER-1:0] per_flag = '0, per_en = '0;
    logic ack = 1'b0, rti = 1'b0;
    logic irq_req, wake;
    logic [2:0] irq_vec;
    logic [1:0] ctx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_nest_ctrl #(.NPER(NPER), .PER_VEC4_MASK(V4M), .PER_STOP_MASK(STM)) dut_i (
        .clk(clk), .rst(rst), .nmi_n(nmi_n), .ext_req(ext_req), .ext_en(ext_en),
        .glb_en(glb_en), .per_flag(per_flag), .per_en(per_en), .lp_mode(lp_mode),
        .ack(ack), .rti(rti), .irq_req(irq_req), .irq_vec(irq_vec), .wake(wake), .ctx(ctx)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock of ack, sample after it
    task automatic do_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0; #1;
    endtask

    task automatic do_rti();
        @(negedge clk); rti = 1'b1;
        @(negedge clk); rti = 1'b0; #1;
    endtask

    // re-arm high long enough to pass the sync chain, then fall; ends 3 edges later
    task automatic nmi_pulse();
        @(negedge clk); nmi_n = 1'b1;
        repeat (3) @(negedge clk);
        nmi_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        check("R9 req after reset", irq_req, 0);
        check("R9 ctx after reset", ctx, 0);

        // R5 R6 R7 R8 exhaustive sweep in normal context with NMI idle
        for (int i = 0; i < 8192; i++) begin
            @(negedge clk);
            ext_req  = i[1:0];
            ext_en   = i[3:2];
            glb_en   = i[4];
            per_flag = i[8:5];
            per_en   = i[12:9];
            begin
                logic [4:0] p;
                logic [3:0] hit;
                int ev;
                logic stop_w;
                hit  = per_flag & per_en & {NPER{glb_en}};
                p[0] = 1'b0;
                p[1] = ext_req[0] & ext_en[0] & glb_en;
                p[2] = ext_req[1] & ext_en[1] & glb_en;
                p[3] = |(hit & ~V4M);
                p[4] = |(hit & V4M);
                ev = 0;
                for (int v = 4; v >= 0; v--) if (p[v]) ev = v;
                stop_w = p[1] | p[2] | (|(hit & STM));
                for (int m = 0; m < 4; m++) begin
                    lp_mode = m[1:0];
                    #1;
                    check("R5 R6 R7 sweep req", irq_req, int'(|p));
                    if (|p) check("R5 sweep vec", irq_vec, ev);
                    check("R8 sweep wake", wake,
                          (m == 1) ? int'(|p) : (m == 2) ? int'(stop_w) : 0);
                end
            end
        end
        @(negedge clk);
        ext_req = '0; ext_en = '0; glb_en = 1'b0; per_flag = '0; per_en = '0; lp_mode = 2'd0;

        // R1 NMI with global enable clear, latency
        @(negedge clk); nmi_n = 1'b0;
        repeat (2) @(negedge clk); #1;
        check("R1 not yet after two edges", irq_req, 0);
        @(negedge clk); #1;
        check("R1 req after three edges", irq_req, 1);
        check("R1 vec zero", irq_vec, 0);
        lp_mode = 2'd2; #1;
        check("R8 nmi wakes stop", wake, 1);
        lp_mode = 2'd0;
        do_ack();
        check("R10 ack nmi from normal", ctx, 2);
        check("R2 latch cleared while held low", irq_req, 0);
        lp_mode = 2'd1; #1;
        check("R2 nothing pending after ack", wake, 0);
        lp_mode = 2'd0;
        repeat (4) @(negedge clk); #1;
        check("R2 held low no new request", irq_req, 0);
        do_rti();
        check("R10 rti nmi to normal", ctx, 0);
        check("R2 no request after return", irq_req, 0);

        // R10 ack without request ignored
        do_ack();
        check("R10 idle ack ignored", ctx, 0);
        do_rti();
        check("R10 rti in normal stays", ctx, 0);

        // R3 R4 nesting
        glb_en = 1'b1; ext_en = 2'b11; ext_req = 2'b01; #1;
        check("R6 vec1 presented", irq_vec, 1);
        do_ack();
        check("R10 ack maskable", ctx, 1);
        ext_req = 2'b11; per_en = 4'hF; per_flag = 4'hF; #1;
        check("R4 no maskable nest", irq_req, 0);
        lp_mode = 2'd1; #1;
        check("R8 blocked source still wakes wait", wake, 1);
        lp_mode = 2'd0;
        nmi_pulse();
        check("R3 nmi over maskable req", irq_req, 1);
        check("R3 nmi over maskable vec", irq_vec, 0);
        do_ack();
        check("R10 nested nmi ctx", ctx, 3);
        nmi_pulse();
        check("R3 nmi not taken in nmi", irq_req, 0);
        do_rti();
        check("R10 nested return", ctx, 1);
        check("R3 latched edge shows after return", irq_req, 1);
        check("R3 latched edge vec", irq_vec, 0);
        do_ack();
        check("R3 second nmi nested", ctx, 3);
        do_rti();
        check("R10 back to maskable", ctx, 1);
        check("R4 still blocked in maskable", irq_req, 0);
        do_rti();
        check("R10 maskable return", ctx, 0);
        check("R5 vec1 first again", irq_vec, 1);

        // R7 held peripheral flag requests again
        ext_req = 2'b00; per_flag = 4'b0100; per_en = 4'b0100; #1;
        check("R7 periph bit2 maps vec4", irq_vec, 4);
        do_ack();
        check("R7 periph serviced ctx", ctx, 1);
        do_rti();
        check("R7 flag held requests again", irq_req, 1);
        check("R7 flag held vec", irq_vec, 4);

        // R9 reset abandons handler and latch
        do_ack();
        check("R9 ctx before reset", ctx, 1);
        per_flag = '0;
        nmi_pulse();
        check("R9 nmi pending before reset", irq_req, 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check("R9 ctx cleared", ctx, 0);
        check("R9 latch cleared", irq_req, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule